// File: doc/BRIEF.md
# SDRAM Command Sequence Monitor

This block sits beside the command bus of a four-bank synchronous DRAM. On every rising clock edge it samples the chip select, the three strobes, the two bank-select lines, the address line that carries the auto-precharge / all-banks flag, and the data mask. It turns the strobes into a command code and keeps a small state machine for each bank. It then flags any command that breaks the ordering rules of the device: mode-register and refresh commands issued while a bank is open, commands squeezed into the quiet window after a mode-register write, column commands issued during an auto-precharge burst, and row or column commands aimed at a bank in the wrong state.

The data mask feeds a short pipeline. Write data is masked in the same cycle the mask is sampled. Read data is switched to high impedance two cycles later. Burst length and row-precharge time are parameters, so the same monitor fits any configuration of the device. A command that is flagged is otherwise ignored, so the tracked bank state keeps following what a correct controller would have done.

Top module: `sdram_cmd_monitor`

## Requirements
- R1: With cs_n low, {ras_n,cas_n,we_n} decodes as 111 no-op (code 0), 011 activate (1), 101 read (2), 100 write (3), 110 burst stop (4), 010 precharge (5), 001 refresh (6), 000 mode-register set (7). With cs_n high the command is a no-op (code 0). The code appears on cmd_o in the cycle after the sampling edge.
- R2: The bank addressed by ba is the bank with index ba (0 to 3). The state of bank i is shown on bank_state_o[2i+1:2i], coded 0 idle, 1 open, 2 auto-precharge burst, 3 recovering. That field shows the state that applies to a command sampled in the current cycle.
- R3: An activate to an idle bank opens it. An activate to a bank that is not idle sets viol_o[4].
- R4: A read or a write to a bank that is not open sets viol_o[3].
- R5: A refresh or a mode-register set while any bank is not idle sets viol_o[0].
- R6: After an accepted mode-register set, any command other than a no-op in either of the next two cycles sets viol_o[1]. The third cycle after it is free.
- R7: A read or write with addr_ap high puts its bank in the burst state for BURST_LEN-1 cycles, then in the recovering state for TRP cycles, then back to idle. Any read or write issued while some bank is in the burst state sets viol_o[2]. Once the burst has ended, a read or write to another open bank is accepted.
- R8: A precharge with addr_ap high sends every open bank to recovering and ignores ba. With addr_ap low, only the bank addressed by ba is sent to recovering. A bank in the recovering state returns to idle after TRP cycles.
- R9: A burst stop ends an auto-precharge burst, and the bank is recovering in the next cycle.
- R10: A command that sets any viol_o bit changes no bank state and does not start a mode-register quiet window.
- R11: viol_o reports the command of the previous cycle only. err_sticky_o rises after any violation and stays high until reset.
- R12: wr_data_en_o is the inverse of dqm in the same cycle. dqm high in cycle n drives rd_dq_oe_o low throughout cycle n+2.
- R13: After reset, cmd_o, viol_o, err_sticky_o and every bank state are 0, and rd_dq_oe_o is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Device clock, rising edge samples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| ba | input | BA_W | Bank select |
| addr_ap | input | 1 | Auto-precharge flag on reads/writes, all-bank flag on precharge |
| dqm | input | 1 | Data mask |
| cmd_o | output | 3 | Decoded command of the previous cycle |
| bank_state_o | output | 2*2^BA_W | Packed per-bank state |
| viol_o | output | 5 | One-cycle violation flags |
| err_sticky_o | output | 1 | Sticky error, cleared only by reset |
| wr_data_en_o | output | 1 | Write data accepted this cycle |
| rd_dq_oe_o | output | 1 | Read data output enable |

## Verification
cmd_o, viol_o and err_sticky_o are due one edge after the command is sampled, and bank_state_o shows at that same edge the state that will judge the next command. The bench drives each command at the falling edge and reads every registered result 1 ns after the next rising edge. wr_data_en_o is combinational and is read between the falling edge where dqm changes and the following rising edge. rd_dq_oe_o is compared against the dqm value driven one command earlier, which places the effect in the second cycle after the mask was sampled. Burst and recovery lengths are counted cycle by cycle from the issuing edge, using the bench parameters BURST_LEN=4 and TRP=2.

// File: rtl/sdcm_pkg.sv
package sdcm_pkg;

    typedef enum logic [2:0] {
        CMD_NOP = 3'd0,
        CMD_ACT = 3'd1,
        CMD_RD  = 3'd2,
        CMD_WR  = 3'd3,
        CMD_BST = 3'd4,
        CMD_PRE = 3'd5,
        CMD_REF = 3'd6,
        CMD_MRS = 3'd7
    } cmd_e;

    typedef enum logic [1:0] {
        BK_IDLE  = 2'd0,
        BK_OPEN  = 2'd1,
        BK_BURST = 2'd2,
        BK_RECOV = 2'd3
    } bank_e;

    localparam int NUM_VIOL   = 5;
    localparam int V_NOT_IDLE = 0;
    localparam int V_MRS_GAP  = 1;
    localparam int V_AP_LOCK  = 2;
    localparam int V_NOT_OPEN = 3;
    localparam int V_ACT_BUSY = 4;

    localparam int MRS_QUIET  = 2;

endpackage

// File: rtl/sdcm_decode.sv
module sdcm_decode
    import sdcm_pkg::*;
(
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    output cmd_e cmd
);
    always_comb begin
        cmd = CMD_NOP;
        if (!cs_n) begin
            unique case ({ras_n, cas_n, we_n})
                3'b111: cmd = CMD_NOP;
                3'b011: cmd = CMD_ACT;
                3'b101: cmd = CMD_RD;
                3'b100: cmd = CMD_WR;
                3'b110: cmd = CMD_BST;
                3'b010: cmd = CMD_PRE;
                3'b001: cmd = CMD_REF;
                3'b000: cmd = CMD_MRS;
                default: cmd = CMD_NOP;
            endcase
        end
    end
endmodule

// File: rtl/sdcm_bank.sv
module sdcm_bank
    import sdcm_pkg::*;
#(
    parameter int BURST_LEN = 4,
    parameter int TRP       = 3
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  go_act,
    input  logic  go_rdwr_ap,
    input  logic  go_pre,
    input  logic  go_bst,
    output bank_e state_o
);
    localparam int CMAX = (BURST_LEN > TRP) ? BURST_LEN : TRP;
    localparam int CW   = $clog2(CMAX + 1);

    typedef struct packed {
        bank_e         st;
        logic [CW-1:0] cnt;
    } bank_s;

    bank_s d, q;

    always_comb begin
        d = q;
        unique case (q.st)
            BK_IDLE: begin
                if (go_act) d.st = BK_OPEN;
            end
            BK_OPEN: begin
                if (go_rdwr_ap) begin
                    if (BURST_LEN == 1) begin
                        d.st  = BK_RECOV;
                        d.cnt = CW'(TRP);
                    end else begin
                        d.st  = BK_BURST;
                        d.cnt = CW'(BURST_LEN - 1);
                    end
                end else if (go_pre) begin
                    d.st  = BK_RECOV;
                    d.cnt = CW'(TRP);
                end
            end
            BK_BURST: begin
                if (go_bst || q.cnt == CW'(1)) begin
                    d.st  = BK_RECOV;
                    d.cnt = CW'(TRP);
                end else begin
                    d.cnt = q.cnt - CW'(1);
                end
            end
            BK_RECOV: begin
                if (q.cnt <= CW'(1)) begin
                    d.st  = BK_IDLE;
                    d.cnt = '0;
                end else begin
                    d.cnt = q.cnt - CW'(1);
                end
            end
            default: d = q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st  <= BK_IDLE;
            q.cnt <= '0;
        end else begin
            q <= d;
        end
    end

    assign state_o = q.st;

    // R7
    idle_to_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == BK_IDLE) |=> (q.st != BK_BURST));

    // R8
    recov_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == BK_RECOV && q.cnt > CW'(1)) |=> (q.st == BK_RECOV));
endmodule

// File: rtl/sdcm_dqm.sv
module sdcm_dqm #(
    parameter int RD_LAT = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic dqm_i,
    output logic wr_en_o,
    output logic rd_oe_o
);
    typedef struct packed {
        logic [RD_LAT-1:0] pipe;
    } dqm_s;

    dqm_s d, q;

    always_comb begin
        d = q;
        if (RD_LAT > 1) d.pipe = {q.pipe[RD_LAT-2:0], dqm_i};
        else            d.pipe[0] = dqm_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign wr_en_o = ~dqm_i;
    assign rd_oe_o = ~q.pipe[RD_LAT-1];

    // R12
    oe_follows_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rd_oe_o) |-> $past(q.pipe[0]));
endmodule

// File: rtl/sdram_cmd_monitor.sv
module sdram_cmd_monitor
    import sdcm_pkg::*;
#(
    parameter int BURST_LEN = 4,
    parameter int TRP       = 3,
    parameter int BA_W      = 2,
    parameter int RD_LAT    = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cs_n,
    input  logic                       ras_n,
    input  logic                       cas_n,
    input  logic                       we_n,
    input  logic [BA_W-1:0]            ba,
    input  logic                       addr_ap,
    input  logic                       dqm,
    output logic [2:0]                 cmd_o,
    output logic [2*(1<<BA_W)-1:0]     bank_state_o,
    output logic [NUM_VIOL-1:0]        viol_o,
    output logic                       err_sticky_o,
    output logic                       wr_data_en_o,
    output logic                       rd_dq_oe_o
);
    localparam int NB = 1 << BA_W;
    localparam int GW = $clog2(MRS_QUIET + 1);

    typedef struct packed {
        cmd_e                cmd;
        logic [NUM_VIOL-1:0] viol;
        logic                err;
        logic [GW-1:0]       gap;
    } mon_s;

    mon_s  d, q;
    cmd_e  cmd;
    bank_e st [NB];
    logic [NB-1:0] go_act, go_ap, go_pre, bursting, idle_v;
    logic [NUM_VIOL-1:0] v;
    logic ok, go_bst;

    sdcm_decode u_dec (
        .cs_n (cs_n),
        .ras_n(ras_n),
        .cas_n(cas_n),
        .we_n (we_n),
        .cmd  (cmd)
    );

    for (genvar i = 0; i < NB; i++) begin : g_bank
        sdcm_bank #(.BURST_LEN(BURST_LEN), .TRP(TRP)) u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .go_act    (go_act[i]),
            .go_rdwr_ap(go_ap[i]),
            .go_pre    (go_pre[i]),
            .go_bst    (go_bst),
            .state_o   (st[i])
        );
        assign bursting[i] = (st[i] == BK_BURST);
        assign idle_v[i]   = (st[i] == BK_IDLE);
        assign bank_state_o[2*i +: 2] = st[i];
    end

    always_comb begin
        v = '0;
        if (cmd != CMD_NOP && q.gap != '0) v[V_MRS_GAP] = 1'b1;
        unique case (cmd)
            CMD_ACT: if (st[ba] != BK_IDLE) v[V_ACT_BUSY] = 1'b1;
            CMD_RD, CMD_WR: begin
                if (|bursting)         v[V_AP_LOCK]  = 1'b1;
                if (st[ba] != BK_OPEN) v[V_NOT_OPEN] = 1'b1;
            end
            CMD_REF, CMD_MRS: if (!(&idle_v)) v[V_NOT_IDLE] = 1'b1;
            default: ;
        endcase
        ok     = (v == '0);
        go_bst = ok && cmd == CMD_BST;
        for (int i = 0; i < NB; i++) begin
            go_act[i] = ok && cmd == CMD_ACT && ba == BA_W'(i);
            go_ap[i]  = ok && (cmd == CMD_RD || cmd == CMD_WR) && addr_ap && ba == BA_W'(i);
            go_pre[i] = ok && cmd == CMD_PRE && (addr_ap || ba == BA_W'(i));
        end

        d      = q;
        d.cmd  = cmd;
        d.viol = v;
        d.err  = q.err | (|v);
        if (ok && cmd == CMD_MRS)  d.gap = GW'(MRS_QUIET);
        else if (q.gap != '0)      d.gap = q.gap - GW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.cmd  <= CMD_NOP;
            q.viol <= '0;
            q.err  <= 1'b0;
            q.gap  <= '0;
        end else begin
            q <= d;
        end
    end

    sdcm_dqm #(.RD_LAT(RD_LAT)) u_dqm (
        .clk    (clk),
        .rst_n  (rst_n),
        .dqm_i  (dqm),
        .wr_en_o(wr_data_en_o),
        .rd_oe_o(rd_dq_oe_o)
    );

    assign cmd_o        = q.cmd;
    assign viol_o       = q.viol;
    assign err_sticky_o = q.err;

    // R11
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.err |=> q.err);

    // R11
    viol_sets_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|q.viol) |-> q.err);

    // R7
    single_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(bursting) <= 1);
endmodule

// File: tb/sim_sdram_cmd_monitor.sv
module sim_sdram_cmd_monitor;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [1:0] ba = 2'b00;
    logic addr_ap = 1'b0;
    logic dqm = 1'b0;
    logic [2:0] cmd_o;
    logic [7:0] bank_state_o;
    logic [4:0] viol_o;
    logic err_sticky_o, wr_data_en_o, rd_dq_oe_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #2 clk = ~clk;

    sdram_cmd_monitor #(.BURST_LEN(4), .TRP(2)) u0 (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
        .we_n(we_n), .ba(ba), .addr_ap(addr_ap), .dqm(dqm), .cmd_o(cmd_o),
        .bank_state_o(bank_state_o), .viol_o(viol_o), .err_sticky_o(err_sticky_o),
        .wr_data_en_o(wr_data_en_o), .rd_dq_oe_o(rd_dq_oe_o)
    );

    localparam logic [2:0] NOP = 0, ACT = 1, RD = 2, WR = 3, BST = 4, PRE = 5, REF = 6, MRS = 7;

    function automatic logic [2:0] pins_of(input logic [2:0] code);
        case (code)
            NOP: return 3'b111; ACT: return 3'b011; RD: return 3'b101; WR: return 3'b100;
            BST: return 3'b110; PRE: return 3'b010; REF: return 3'b001; default: return 3'b000;
        endcase
    endfunction

    function automatic logic [2:0] code_of(input logic [2:0] p);
        case (p)
            3'b111: return NOP; 3'b011: return ACT; 3'b101: return RD; 3'b100: return WR;
            3'b110: return BST; 3'b010: return PRE; 3'b001: return REF; default: return MRS;
        endcase
    endfunction

    function automatic logic [7:0] st4(input int s3, input int s2, input int s1, input int s0);
        return {s3[1:0], s2[1:0], s1[1:0], s0[1:0]};
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic raw(input logic c, input logic [2:0] p, input logic [1:0] b,
                       input logic ap, input logic dm);
        @(negedge clk);
        cs_n = c; {ras_n, cas_n, we_n} = p; ba = b; addr_ap = ap; dqm = dm;
        @(posedge clk);
        #1;
    endtask

    task automatic issue(input logic [2:0] code, input logic [1:0] b, input logic ap);
        raw(1'b0, pins_of(code), b, ap, 1'b0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; cs_n = 1'b1; {ras_n, cas_n, we_n} = 3'b111; dqm = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [19:0] pat;
        pat = 20'hB3A5C;

        // R13 reset state
        do_reset();
        #1;
        chk("R13 cmd", cmd_o, 0);
        chk("R13 state", bank_state_o, 0);
        chk("R13 viol", viol_o, 0);
        chk("R13 err", err_sticky_o, 0);
        chk("R13 oe", rd_dq_oe_o, 1);

        // R1 decode sweep over all select/strobe combinations
        for (int i = 0; i < 16; i++) begin
            logic [3:0] iv;
            iv = 4'(i);
            raw(iv[3], iv[2:0], 2'b11, 1'b0, 1'b0);
            chk("R1 decode", cmd_o, iv[3] ? 0 : int'(code_of(iv[2:0])));
        end

        // R3 R2 activate by bank select, then double activate
        do_reset();
        issue(ACT, 2'b01, 0);
        chk("R2 bank select", bank_state_o, st4(0, 0, 1, 0));
        chk("R3 open ok", viol_o, 0);
        issue(ACT, 2'b01, 0);
        chk("R3 act busy", viol_o, 5'b10000);
        chk("R11 err set", err_sticky_o, 1);
        issue(NOP, 0, 0);
        chk("R11 one cycle", viol_o, 0);
        chk("R11 sticky", err_sticky_o, 1);
        issue(ACT, 2'b11, 0);
        chk("R11 sticky hold", err_sticky_o, 1);
        chk("R2 bank d", bank_state_o, st4(1, 0, 1, 0));

        // R4 read to idle bank
        do_reset();
        issue(RD, 2'b10, 0);
        chk("R4 not open", viol_o, 5'b01000);
        issue(WR, 2'b00, 0);
        chk("R4 write not open", viol_o, 5'b01000);

        // R6 R10 R5 mode-register quiet window
        do_reset();
        issue(MRS, 0, 0);
        chk("R6 mrs legal", viol_o, 0);
        issue(ACT, 0, 0);
        chk("R6 gap first", viol_o, 5'b00010);
        chk("R10 ignored", bank_state_o, 0);
        issue(BST, 0, 0);
        chk("R6 gap second", viol_o, 5'b00010);
        issue(ACT, 0, 0);
        chk("R6 third free", viol_o, 0);
        chk("R6 opened", bank_state_o, st4(0, 0, 0, 1));
        issue(REF, 0, 0);
        chk("R5 ref busy", viol_o, 5'b00001);
        issue(MRS, 0, 0);
        chk("R5 mrs busy", viol_o, 5'b00001);
        issue(ACT, 1, 0);
        chk("R10 no gap", viol_o, 0);
        chk("R10 state", bank_state_o, st4(0, 0, 1, 1));

        // R7 auto-precharge burst, lockout, recovery
        do_reset();
        issue(ACT, 0, 0);
        issue(ACT, 1, 0);
        issue(RD, 0, 1);
        chk("R7 burst", bank_state_o, st4(0, 0, 1, 2));
        issue(WR, 1, 0);
        chk("R7 lockout", viol_o, 5'b00100);
        issue(NOP, 0, 0);
        chk("R7 still burst", bank_state_o, st4(0, 0, 1, 2));
        issue(NOP, 0, 0);
        chk("R7 recovering", bank_state_o, st4(0, 0, 1, 3));
        issue(RD, 1, 0);
        chk("R7 other bank", viol_o, 0);
        issue(ACT, 0, 0);
        chk("R7 act during trp", viol_o, 5'b10000);
        chk("R7 idle", bank_state_o, st4(0, 0, 1, 0));
        issue(ACT, 0, 0);
        chk("R7 act after trp", viol_o, 0);

        // R8 all-bank precharge
        issue(PRE, 2'b10, 1);
        chk("R8 all", bank_state_o, st4(0, 0, 3, 3));
        issue(NOP, 0, 0);
        chk("R8 trp", bank_state_o, st4(0, 0, 3, 3));
        issue(NOP, 0, 0);
        chk("R8 idle", bank_state_o, 0);
        issue(REF, 0, 0);
        chk("R5 ref legal", viol_o, 0);

        // R8 single-bank precharge
        do_reset();
        issue(ACT, 0, 0);
        issue(ACT, 1, 0);
        issue(PRE, 1, 0);
        chk("R8 single", bank_state_o, st4(0, 0, 3, 1));

        // R9 burst stop
        do_reset();
        issue(ACT, 2, 0);
        issue(ACT, 0, 0);
        issue(WR, 2, 1);
        chk("R9 burst", bank_state_o, st4(0, 2, 0, 1));
        issue(BST, 0, 0);
        chk("R9 stopped", bank_state_o, st4(0, 3, 0, 1));
        issue(RD, 0, 0);
        chk("R9 lock lifted", viol_o, 0);
        issue(NOP, 0, 0);
        chk("R9 idle", bank_state_o, st4(0, 0, 0, 1));

        // R12 mask pipeline sweep
        do_reset();
        issue(NOP, 0, 0);
        issue(NOP, 0, 0);
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            cs_n = 1'b1; dqm = pat[k];
            #1;
            chk("R12 write mask", wr_data_en_o, pat[k] ? 0 : 1);
            @(posedge clk);
            #1;
            chk("R12 read oe", rd_dq_oe_o, (k == 0) ? 1 : (pat[k-1] ? 0 : 1));
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule